// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Register Bank

This block is the software-visible register bank of a DRAM controller. It sits on a simple word-access register bus: one request strobe, a write enable, a byte address inside a 4 KiB window, write data, registered read data and a one-cycle error pulse. Register 0 holds a protection key, and every write to another register is refused unless that key register currently holds the unlock value 0xFC600309. Register 1 is the controller configuration word. Its lowest two bits carry a DRAM size code, which is loaded at reset from a RAM size input given in megabytes. The remaining registers are plain 32-bit storage.

A parameter picks one of two controller generations. Each generation has its own size table, its own set of read-only configuration bits and its own reset image. When software writes the configuration word, the read-only positions keep their current value and only the writable positions take the new data. The configuration bits for timing, scrambling, error correction and caching are stored here and nothing else. No logic in this block acts on them.

The lock is kept by a two-state machine, reset into `LK_LOCKED`. A write of the unlock value to register 0 moves it to `LK_OPEN` (transition *unlock*). From `LK_OPEN`, a write of any other value to register 0 moves it back to `LK_LOCKED` (transition *relock*). In either state, every other access leaves the state unchanged (transitions *hold_locked* and *hold_open*). A write of the key in `LK_OPEN` also holds the state.

Top module: `memcfg_regs`

## Requirements
- R1: While reset is held and after it is released, the bank is in a known state. Read data and error are 0. The key register and all plain registers are 0, and the bank is locked. The configuration word is 0x00000040 plus the size code on the first generation, and 0x1000000C plus the size code on the second.
- R2: On the first generation, a RAM size of 64, 128, 256 or 512 MB gives size code 0, 1, 2 or 3 in configuration bits 1:0. Any other size gives code 2.
- R3: On the second generation, a RAM size of 128, 256, 512 or 1024 MB gives size code 0, 1, 2 or 3 in configuration bits 1:0. Any other size gives code 2.
- R4: Register 0 (byte address 0x000) takes any written value at any time, with no error, and reads it back.
- R5: While locked, a write to an implemented register other than register 0 changes nothing and raises the error. Reads of every implemented register are allowed while locked.
- R6: Writing register 0 with any value other than 0xFC600309 locks the bank for every access that follows.
- R7: On the first generation, a configuration write keeps bits 31:11, bit 6 and bits 3:2 (mask 0xFFFFF84C) and takes all other bits from the write data.
- R8: On the second generation, a configuration write keeps bits 31:28, bits 19:14, bit 6 and bits 3:2 (mask 0xF00FC04C) and takes all other bits from the write data.
- R9: An aligned access whose word index (address bits 11:2) is at or above the number of implemented registers (4 by default) raises the error. A read of such an index returns 0, and a write to it is dropped.
- R10: An access whose address bits 1:0 are not zero raises the error. A read returns 0, and a write changes no register, even while unlocked.
- R11: Read data and error are registered. Both appear in the cycle after the request. The error is high for exactly one cycle per failing request and is 0 in any cycle that follows a cycle with no request.
- R12: The RAM size input is taken only while reset is held. Changing it afterwards leaves the configuration word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the reset image |
| ram_mb | input | RAM_W | Installed RAM size in megabytes, sampled during reset |
| req | input | 1 | Access request strobe, one access per cycle |
| wr_en | input | 1 | 1 = write, 0 = read, qualified by req |
| addr | input | ADDR_W | Byte address inside the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| err | output | 1 | One-cycle error pulse the cycle after a failing request |

## Verification
If the lock state were wrong, a write after a relock would land, or a write after an unlock would be refused. Either fault shows at the ports on the very next access: as a changed readback, or as a wrong error pulse in the cycle after that write. If the read-only mask or the reset image were wrong, the first configuration read after reset or after a write would show it, so the bench reads the configuration word after every configuration write and after every reset, on both generations side by side. If the size table were wrong, a reset with that RAM size followed by one read would show it. The fallback code and the rule that the RAM size is taken only during reset are each checked by one reset and one read.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    // Word width of every register in the bank
    localparam int REG_W = 32;

    // Value register 0 must hold for writes elsewhere to land
    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

    // Fixed register roles; the rest are plain storage
    localparam int KEY_IDX = 0;
    localparam int CFG_IDX = 1;

    // Size code width in the configuration word (bits 1:0)
    localparam int SIZE_W = 2;

    typedef enum logic {
        GEN_FIRST  = 1'b0,
        GEN_SECOND = 1'b1
    } gen_e;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_e;

    // Bits of the configuration word that software cannot change
    function automatic logic [REG_W-1:0] cfg_ro_mask(input gen_e g);
        logic [REG_W-1:0] m;
        m = '0;
        m[6]   = 1'b1;
        m[3:2] = 2'b11;
        if (g == GEN_FIRST) begin
            m[31:11] = '1;
        end else begin
            m[31:28] = 4'hF;
            m[19:14] = 6'h3F;
        end
        return m;
    endfunction

    // Configuration word after reset, without the size code
    function automatic logic [REG_W-1:0] cfg_reset_base(input gen_e g);
        logic [REG_W-1:0] v;
        v = '0;
        if (g == GEN_FIRST) begin
            v[6] = 1'b1;
        end else begin
            v[31:28] = 4'h1;
            v[3:2]   = 2'b11;
        end
        return v;
    endfunction

endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 4,
    localparam int WORD_W  = ADDR_W - 2,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              in_range;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = (int'(word) < NUM_REGS);
        hit      = aligned && in_range;
        idx      = word[IDX_W-1:0];
    end

endmodule

// File: rtl/memcfg_size_enc.sv
module memcfg_size_enc
    import memcfg_pkg::*;
#(
    parameter gen_e GEN   = GEN_FIRST,
    parameter int   RAM_W = 16
) (
    input  logic [RAM_W-1:0]  ram_mb,
    output logic [SIZE_W-1:0] code
);

    generate
        if (GEN == GEN_FIRST) begin : g_first
            always_comb begin
                unique case (ram_mb)
                    RAM_W'(64):  code = 2'd0;
                    RAM_W'(128): code = 2'd1;
                    RAM_W'(256): code = 2'd2;
                    RAM_W'(512): code = 2'd3;
                    default:     code = 2'd2;
                endcase
            end
        end else begin : g_second
            always_comb begin
                unique case (ram_mb)
                    RAM_W'(128):  code = 2'd0;
                    RAM_W'(256):  code = 2'd1;
                    RAM_W'(512):  code = 2'd2;
                    RAM_W'(1024): code = 2'd3;
                    default:      code = 2'd2;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/memcfg_lock_fsm.sv
module memcfg_lock_fsm
    import memcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [REG_W-1:0] key_data,
    output logic             unlocked
);

    lock_e state_q;
    lock_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_data == UNLOCK_KEY) state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && key_data != UNLOCK_KEY) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            LK_OPEN:   unlocked = 1'b1;
            default:   unlocked = 1'b0;
        endcase
    end

    // R6
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != UNLOCK_KEY) |=> !unlocked);

    // R4
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == UNLOCK_KEY) |=> unlocked);

endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
    import memcfg_pkg::*;
#(
    parameter gen_e GEN      = GEN_FIRST,
    parameter int   ADDR_W   = 12,
    parameter int   NUM_REGS = 4,
    parameter int   RAM_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAM_W-1:0]  ram_mb,
    input  logic              req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              err
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [REG_W-1:0] RO_MASK  = cfg_ro_mask(GEN);
    localparam logic [REG_W-1:0] CFG_BASE = cfg_reset_base(GEN);

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [SIZE_W-1:0] size_code;
    logic              unlocked;
    logic              wr_hit;
    logic              key_wr;
    logic              wr_ok;
    logic              wr_blocked;
    logic [REG_W-1:0]  rd_vec [NUM_REGS];

    memcfg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .addr (addr),
        .idx  (idx),
        .hit  (hit)
    );

    memcfg_size_enc #(
        .GEN   (GEN),
        .RAM_W (RAM_W)
    ) u_size (
        .ram_mb (ram_mb),
        .code   (size_code)
    );

    always_comb begin
        wr_hit     = req && wr_en && hit;
        key_wr     = wr_hit && (idx == IDX_W'(KEY_IDX));
        wr_ok      = key_wr || (wr_hit && unlocked);
        wr_blocked = wr_hit && !key_wr && !unlocked;
    end

    memcfg_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdata),
        .unlocked (unlocked)
    );

    // Register storage, one slot per index
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [REG_W-1:0] q;
            logic             we;
            assign we = wr_ok && (idx == IDX_W'(i));
            if (i == CFG_IDX) begin : g_cfg
                always_ff @(posedge clk) begin
                    if (!rst_n)  q <= CFG_BASE | {{(REG_W-SIZE_W){1'b0}}, size_code};
                    else if (we) q <= (q & RO_MASK) | (wdata & ~RO_MASK);
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (!rst_n)  q <= '0;
                    else if (we) q <= wdata;
                end
            end
            assign rd_vec[i] = q;
        end
    endgenerate

    // Response stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= req && (!hit || wr_blocked);
            if (req && !wr_en) rdata <= hit ? rd_vec[idx] : '0;
        end
    end

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !key_wr && !unlocked) |=> ($stable(rd_vec[CFG_IDX]) && err));

    // R7 R8
    ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(rd_vec[CFG_IDX] & RO_MASK));

    // R9
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_en && !hit) |=> (err && rdata == '0));

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !err);

endmodule

// File: tb/tb_memcfg_regs.sv
`timescale 1ns/1ps
module tb_memcfg_regs;
    import memcfg_pkg::*;

    localparam int NREG = 4;
    localparam logic [31:0] KEYV = 32'hFC60_0309;
    localparam logic [31:0] RO_A = 32'hFFFF_F84C;
    localparam logic [31:0] RO_B = 32'hF00F_C04C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [15:0] ram_a = 16'd256;
    logic [15:0] ram_b = 16'd512;
    logic [31:0] rdata_a, rdata_b;
    logic        err_a, err_b;
    logic        chk_next = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    memcfg_regs #(.GEN(GEN_FIRST)) dut (
        .clk(clk), .rst_n(rst_n), .ram_mb(ram_a), .req(req), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_a), .err(err_a));

    memcfg_regs #(.GEN(GEN_SECOND)) dut_g2 (
        .clk(clk), .rst_n(rst_n), .ram_mb(ram_b), .req(req), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_b), .err(err_b));

    typedef struct {
        bit          is_rd;
        logic [31:0] ra;
        logic [31:0] rb;
        bit          ea;
        bit          eb;
        string       tag;
    } item_t;

    item_t sb[$];

    // Bench model
    bit          m_open;
    logic [31:0] m_a [NREG];
    logic [31:0] m_b [NREG];

    function automatic logic [1:0] code_first(input int mb);
        case (mb)
            64:  return 2'd0;
            128: return 2'd1;
            256: return 2'd2;
            512: return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] code_second(input int mb);
        case (mb)
            128:  return 2'd0;
            256:  return 2'd1;
            512:  return 2'd2;
            1024: return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int a, input int b);
        @(negedge clk);
        rst_n = 1'b0;
        ram_a = 16'(a);
        ram_b = 16'(b);
        repeat (3) @(negedge clk);
        check(rdata_a == 0 && err_a == 0, "R1 reset outputs gen1", {rdata_a[30:0], err_a}, 0);
        check(rdata_b == 0 && err_b == 0, "R1 reset outputs gen2", {rdata_b[30:0], err_b}, 0);
        rst_n = 1'b1;
        m_open = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            m_a[i] = '0;
            m_b[i] = '0;
        end
        m_a[1] = 32'h0000_0040 | {30'b0, code_first(a)};
        m_b[1] = 32'h1000_000C | {30'b0, code_second(b)};
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string tag);
        item_t it;
        int w;
        bit bad;
        w = int'(a[11:2]);
        bad = (a[1:0] != 2'b00) || (w >= NREG);
        it.is_rd = 1'b0; it.ra = '0; it.rb = '0; it.tag = tag;
        if (bad) begin
            it.ea = 1'b1; it.eb = 1'b1;
        end else if (w == 0) begin
            it.ea = 1'b0; it.eb = 1'b0;
            m_a[0] = d; m_b[0] = d;
            m_open = (d == KEYV);
        end else if (!m_open) begin
            it.ea = 1'b1; it.eb = 1'b1;
        end else begin
            it.ea = 1'b0; it.eb = 1'b0;
            if (w == 1) begin
                m_a[1] = (m_a[1] & RO_A) | (d & ~RO_A);
                m_b[1] = (m_b[1] & RO_B) | (d & ~RO_B);
            end else begin
                m_a[w] = d; m_b[w] = d;
            end
        end
        @(negedge clk);
        req = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        sb.push_back(it);
        @(negedge clk);
        req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        item_t it;
        int w;
        bit bad;
        w = int'(a[11:2]);
        bad = (a[1:0] != 2'b00) || (w >= NREG);
        it.is_rd = 1'b1; it.tag = tag;
        if (bad) begin
            it.ra = '0; it.rb = '0; it.ea = 1'b1; it.eb = 1'b1;
        end else begin
            it.ra = m_a[w]; it.rb = m_b[w]; it.ea = 1'b0; it.eb = 1'b0;
        end
        @(negedge clk);
        req = 1'b1; wr_en = 1'b0; addr = a; wdata = 32'hDEAD_BEEF;
        sb.push_back(it);
        @(negedge clk);
        req = 1'b0;
    endtask

    always @(posedge clk) chk_next <= rst_n && req;

    // Monitor: compare results the cycle after each request
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_next) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 response with empty scoreboard", 0, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(err_a == it.ea, {it.tag, " err gen1"}, {31'b0, err_a}, {31'b0, it.ea});
                    check(err_b == it.eb, {it.tag, " err gen2"}, {31'b0, err_b}, {31'b0, it.eb});
                    if (it.is_rd) begin
                        check(rdata_a == it.ra, {it.tag, " data gen1"}, rdata_a, it.ra);
                        check(rdata_b == it.rb, {it.tag, " data gen2"}, rdata_b, it.rb);
                    end
                end
            end else begin
                check(!err_a && !err_b, "R11 error idle", {30'b0, err_b, err_a}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int mbs [8];
        mbs = '{64, 128, 256, 512, 1024, 100, 0, 2048};

        do_reset(256, 512);
        bus_read(12'h004, "R1 R2 R3 reset config");
        bus_read(12'h000, "R1 reset key");
        bus_read(12'h008, "R1 reset plain2");
        bus_read(12'h00C, "R1 reset plain3");

        // Locked bank
        bus_write(12'h004, 32'hFFFF_FFFF, "R5 locked cfg write");
        bus_read(12'h004, "R5 cfg after locked write");
        bus_write(12'h008, 32'h1234_5678, "R5 locked plain write");
        bus_read(12'h008, "R5 plain after locked write");

        // Non-key values in register 0
        bus_write(12'h000, 32'h1234_5678, "R4 any key write");
        bus_read(12'h000, "R4 key readback");
        bus_write(12'h00C, 32'h0BAD_0BAD, "R5 still locked");
        bus_read(12'h00C, "R5 plain after wrong key");

        // Unlock and write
        bus_write(12'h000, KEYV, "R4 unlock write");
        bus_write(12'h008, 32'hA5A5_0001, "R5 open plain write");
        bus_read(12'h008, "R5 open plain readback");
        bus_write(12'h004, 32'hFFFF_FFFF, "R7 R8 cfg write ones");
        bus_read(12'h004, "R7 R8 cfg after ones");
        bus_write(12'h004, 32'h0000_0000, "R7 R8 cfg write zeros");
        bus_read(12'h004, "R7 R8 cfg after zeros");
        bus_write(12'h004, 32'h5A5A_A5A5, "R7 R8 cfg write pattern");
        bus_read(12'h004, "R7 R8 cfg after pattern");

        // Out of range and misaligned while open
        bus_read(12'h010, "R9 read index 4");
        bus_read(12'hFFC, "R9 read top of window");
        bus_write(12'h010, 32'h1111_1111, "R9 write index 4");
        bus_read(12'h005, "R10 misaligned read");
        bus_write(12'h006, 32'hFFFF_FFFF, "R10 misaligned write");
        bus_write(12'h00B, 32'h2222_2222, "R10 misaligned plain write");
        bus_read(12'h004, "R10 cfg after misaligned write");
        bus_read(12'h008, "R10 plain after misaligned write");

        // Relock
        bus_write(12'h000, 32'h0000_0000, "R6 relock write");
        bus_write(12'h00C, 32'h3333_3333, "R6 write after relock");
        bus_read(12'h00C, "R6 plain after relock");
        bus_write(12'h004, 32'h0000_0003, "R6 cfg write after relock");
        bus_read(12'h004, "R6 cfg after relock");

        // Back-to-back: unlock then relock with the key plus one
        bus_write(12'h000, KEYV, "R4 unlock again");
        bus_write(12'h000, KEYV + 32'd1, "R6 near-key relock");
        bus_write(12'h008, 32'h4444_4444, "R6 write after near-key");
        bus_read(12'h008, "R6 plain after near-key");

        // Size tables
        foreach (mbs[i]) begin
            do_reset(mbs[i], mbs[i]);
            bus_read(12'h004, "R2 R3 size code");
        end

        // RAM size changes after reset
        do_reset(128, 1024);
        ram_a = 16'd512;
        ram_b = 16'd128;
        repeat (3) @(negedge clk);
        bus_read(12'h004, "R12 cfg after size change");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule